// File: doc/BRIEF.md
# Programmable Chip Select Generator

This block sits between a bus master and external memory or peripheral devices. Software loads eight region descriptors through a small configuration write port. Each region has a base word and an option word. When the master raises a request with an address and a direction, the block compares that address against every region at once. If more than one region claims the address, the lowest-numbered region wins. The block then drives that region's active-low select line for the length of the transfer.

The option word sets the shape of each transfer. It can add a setup cycle before the select asserts. For writes, it can delay the write strobe by one more cycle. It can keep address and data driven for one cycle after a write ends. It also sets the number of wait states, and it can restrict a region to reads only or to writes only. The block ends a transfer itself when the wait-state counter runs out, or earlier if an external acknowledge arrives. While a transfer is in progress, new requests are not accepted.

Top module: `csg_top`

## Requirements
- R1: After reset, every `cs_n` bit and `rw_n` are high, and `xfer_done` and `drv_en` are low. Every base word resets to zero, so every region is invalid. Every option word resets to 0xFFFF_F078: full mask, no setup, no write hold, 30 wait states, no direction restriction.
- R2: Base word layout: bits 31..12 are the region address and bit 0 is the valid flag. In the option word, bits 31..12 are the mask. An address bit whose mask bit is 1 must equal the base bit. An address bit whose mask bit is 0 is ignored. Address bits 11..0 never take part in the match.
- R3: When several valid regions match, only the lowest-numbered one asserts its select. At most one `cs_n` bit is ever low.
- R4: With option bit 11 (setup) clear, a request accepted at the clock edge that samples `bus_req` drives the select low in the cycle that follows that edge. `drv_en` rises in the same cycle.
- R5: With option bit 11 set, `drv_en` rises one cycle after the request and the select asserts one cycle later than under R4. For a write, `rw_n` goes low one cycle after the select. For a read, `rw_n` stays high.
- R6: Option bits 6..2 give the wait-state count N. After the strobe phase begins (the select, or the delayed write strobe under R5), the select stays low for N+1 cycles. `xfer_done` pulses high in the last of those cycles, and the select goes high in the next cycle.
- R7: If `ext_ack` is high in a strobe-phase cycle before the count runs out, `xfer_done` pulses in that cycle and the transfer ends. `ext_ack` has no effect during the setup cycle or the delayed-strobe cycle.
- R8: With option bit 10 (write hold) set, `drv_en` stays high for one cycle after the select and `rw_n` go high at the end of a write. Without bit 10, or on a read, `drv_en` falls together with the select.
- R9: Option bit 0 set restricts the region to one direction. It then matches only when `bus_rd` equals option bit 1 (1 = read). With bit 0 clear, the region matches both reads and writes.
- R10: A request that matches no valid region asserts no select and raises neither `drv_en` nor `xfer_done`.
- R11: `bus_req` is ignored while a transfer is in progress. The current transfer keeps its timing, and no second transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel_opt | input | 1 | 1 writes the option word, 0 writes the base word |
| cfg_idx | input | 3 | Region written |
| cfg_wdata | input | 32 | Configuration write data |
| bus_req | input | 1 | Transfer request, sampled only while idle |
| bus_addr | input | 32 | Transfer address |
| bus_rd | input | 1 | Direction: 1 read, 0 write |
| ext_ack | input | 1 | External early termination |
| cs_n | output | 8 | Active-low region selects |
| rw_n | output | 1 | Active-low write strobe |
| xfer_done | output | 1 | Transfer termination pulse |
| drv_en | output | 1 | Address, data and attribute drive enable |

## Verification
Cycle 0 is the cycle in which the bench drives `bus_req`. With no setup cycle, the select and `drv_en` change in cycle 1. A setup cycle pushes the select to cycle 2, and a delayed write strobe pushes `rw_n` to cycle 3. `xfer_done` lands N cycles after the first strobe cycle, or in the cycle that carries `ext_ack`. The write hold adds exactly one `drv_en` cycle after that. For each transfer, the bench computes this timeline from its own copy of the region words and its own priority search. It then compares all four outputs in the middle of every cycle from cycle 0 to two cycles past the end, so an early edge, a late edge or an extra edge each fails a check.

// File: rtl/csg_pkg.sv
package csg_pkg;
  // Fixed option/base field positions
  localparam int MLSB      = 12;
  localparam int BIT_ASET  = 11;
  localparam int BIT_WRAH  = 10;
  localparam int WS_LSB    = 2;
  localparam int WS_W      = 5;
  localparam int BIT_RWSEL = 1;
  localparam int BIT_RWMSK = 0;
  localparam int BIT_VLD   = 0;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_HOLD   = 2'd3
  } csg_state_e;
endpackage

// File: rtl/csg_regs.sv
module csg_regs
  import csg_pkg::*;
#(
  parameter int NUM = 8,
  parameter int AW  = 32,
  parameter logic [31:0] OPT_RST = 32'hFFFF_F078,
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1,
  localparam int HW    = AW - MLSB
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic                          cfg_sel_opt,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic [AW-1:0]                 cfg_wdata,
  output logic [NUM-1:0][HW-1:0]        base_hi,
  output logic [NUM-1:0]                base_vld,
  output logic [NUM-1:0][HW-1:0]        mask_hi,
  output logic [NUM-1:0]                opt_aset,
  output logic [NUM-1:0]                opt_wrah,
  output logic [NUM-1:0][WS_W-1:0]      opt_ws,
  output logic [NUM-1:0]                opt_rwsel,
  output logic [NUM-1:0]                opt_rwmsk
);
  // bits carried in the option word with no timing effect here
  logic cfg_unused;
  assign cfg_unused = ^cfg_wdata[BIT_WRAH-1:WS_LSB+WS_W];

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic base_en, opt_en;
    assign base_en = cfg_we && !cfg_sel_opt && (cfg_idx == IDX_W'(g));
    assign opt_en  = cfg_we &&  cfg_sel_opt && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_hi[g]  <= '0;
        base_vld[g] <= 1'b0;
      end else if (base_en) begin
        base_hi[g]  <= cfg_wdata[AW-1:MLSB];
        base_vld[g] <= cfg_wdata[BIT_VLD];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_hi[g]   <= {HW{1'b1}};
        opt_aset[g]  <= OPT_RST[BIT_ASET];
        opt_wrah[g]  <= OPT_RST[BIT_WRAH];
        opt_ws[g]    <= OPT_RST[WS_LSB +: WS_W];
        opt_rwsel[g] <= OPT_RST[BIT_RWSEL];
        opt_rwmsk[g] <= OPT_RST[BIT_RWMSK];
      end else if (opt_en) begin
        mask_hi[g]   <= cfg_wdata[AW-1:MLSB];
        opt_aset[g]  <= cfg_wdata[BIT_ASET];
        opt_wrah[g]  <= cfg_wdata[BIT_WRAH];
        opt_ws[g]    <= cfg_wdata[WS_LSB +: WS_W];
        opt_rwsel[g] <= cfg_wdata[BIT_RWSEL];
        opt_rwmsk[g] <= cfg_wdata[BIT_RWMSK];
      end
    end
  end
endmodule

// File: rtl/csg_decode.sv
module csg_decode
  import csg_pkg::*;
#(
  parameter int NUM = 8,
  parameter int AW  = 32,
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1,
  localparam int HW    = AW - MLSB
) (
  input  logic [HW-1:0]           addr_hi,
  input  logic                    is_rd,
  input  logic [NUM-1:0][HW-1:0]  base_hi,
  input  logic [NUM-1:0]          base_vld,
  input  logic [NUM-1:0][HW-1:0]  mask_hi,
  input  logic [NUM-1:0]          opt_rwsel,
  input  logic [NUM-1:0]          opt_rwmsk,
  output logic                    hit,
  output logic [IDX_W-1:0]        hit_idx
);
  logic [NUM-1:0] match;

  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    logic addr_ok, dir_ok;
    assign addr_ok  = ((addr_hi ^ base_hi[g]) & mask_hi[g]) == '0;
    assign dir_ok   = !opt_rwmsk[g] || (opt_rwsel[g] == is_rd);
    assign match[g] = base_vld[g] && addr_ok && dir_ok;
  end

  // scan from the top so the lowest index is the last to write
  always_comb begin
    hit_idx = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/csg_fsm.sv
module csg_fsm
  import csg_pkg::*;
#(
  parameter int NUM = 8,
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              is_rd,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic              sel_aset,
  input  logic              sel_wrah,
  input  logic [WS_W-1:0]   sel_ws,
  input  logic              ext_ack,
  output logic [NUM-1:0]    cs_n,
  output logic              rw_n,
  output logic              xfer_done,
  output logic              drv_en
);
  csg_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic             wr_q, wrah_q, pend_q, pend_d;
  logic [WS_W-1:0]  cnt_q, cnt_d;
  logic             cap_en, cnt_en, fin;

  assign cap_en = (st_q == ST_IDLE) && bus_req && hit;

  // next-state process
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    fin    = 1'b0;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cap_en) begin
          cnt_d  = sel_ws;
          cnt_en = 1'b1;
          pend_d = sel_aset && !is_rd;
          st_d   = sel_aset ? ST_SETUP : ST_ACTIVE;
        end
      end
      ST_SETUP: st_d = ST_ACTIVE;
      ST_ACTIVE: begin
        if (pend_q) begin
          pend_d = 1'b0;
        end else if ((cnt_q == '0) || ext_ack) begin
          fin  = 1'b1;
          st_d = (wr_q && wrah_q) ? ST_HOLD : ST_IDLE;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_HOLD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      wr_q   <= 1'b0;
      wrah_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      if (cap_en) begin
        idx_q  <= hit_idx;
        wr_q   <= !is_rd;
        wrah_q <= sel_wrah;
      end
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  always_comb begin
    cs_n = '1;
    if (st_q == ST_ACTIVE) cs_n[idx_q] = 1'b0;
  end

  assign rw_n      = !((st_q == ST_ACTIVE) && wr_q && !pend_q);
  assign xfer_done = fin;
  assign drv_en    = (st_q != ST_IDLE);
endmodule

// File: rtl/csg_top.sv
module csg_top
  import csg_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int AW     = 32,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int HW    = AW - MLSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel_opt,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              bus_req,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_rd,
  input  logic              ext_ack,
  output logic [NUM_CS-1:0] cs_n,
  output logic              rw_n,
  output logic              xfer_done,
  output logic              drv_en
);
  // reset: asserted asynchronously, released after two clock edges
  logic rst_s0, rst_s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end

  logic addr_unused;
  assign addr_unused = ^bus_addr[MLSB-1:0];

  logic [NUM_CS-1:0][HW-1:0]   base_hi, mask_hi;
  logic [NUM_CS-1:0]           base_vld, opt_aset, opt_wrah, opt_rwsel, opt_rwmsk;
  logic [NUM_CS-1:0][WS_W-1:0] opt_ws;
  logic                        hit;
  logic [IDX_W-1:0]            hit_idx;

  csg_regs #(.NUM(NUM_CS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_s1),
    .cfg_we(cfg_we), .cfg_sel_opt(cfg_sel_opt), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .base_hi(base_hi), .base_vld(base_vld), .mask_hi(mask_hi),
    .opt_aset(opt_aset), .opt_wrah(opt_wrah), .opt_ws(opt_ws),
    .opt_rwsel(opt_rwsel), .opt_rwmsk(opt_rwmsk)
  );

  csg_decode #(.NUM(NUM_CS), .AW(AW)) u_dec (
    .addr_hi(bus_addr[AW-1:MLSB]), .is_rd(bus_rd),
    .base_hi(base_hi), .base_vld(base_vld), .mask_hi(mask_hi),
    .opt_rwsel(opt_rwsel), .opt_rwmsk(opt_rwmsk),
    .hit(hit), .hit_idx(hit_idx)
  );

  csg_fsm #(.NUM(NUM_CS)) u_fsm (
    .clk(clk), .rst_n(rst_s1),
    .bus_req(bus_req), .is_rd(bus_rd), .hit(hit), .hit_idx(hit_idx),
    .sel_aset(opt_aset[hit_idx]), .sel_wrah(opt_wrah[hit_idx]), .sel_ws(opt_ws[hit_idx]),
    .ext_ack(ext_ack),
    .cs_n(cs_n), .rw_n(rw_n), .xfer_done(xfer_done), .drv_en(drv_en)
  );
endmodule

// File: rtl/csg_checker.sv
module csg_checker #(
  parameter int NUM = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NUM-1:0] cs_n,
  input logic           rw_n,
  input logic           xfer_done,
  input logic           drv_en
);
  p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_done_inside_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (cs_n != '1));

  p_cs_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (cs_n == '1));

  p_cs_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n != '1) && !xfer_done) |=> $stable(cs_n));

  p_strobe_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |-> (cs_n != '1));

  p_drive_covers_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |-> drv_en);

  p_hold_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_done) && drv_en) |=> !drv_en);
endmodule

bind csg_top csg_checker #(.NUM(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw_n(rw_n),
  .xfer_done(xfer_done), .drv_en(drv_en)
);

// File: tb/sim_csg_top.sv
module sim_csg_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel_opt;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        bus_req, bus_rd, ext_ack;
  logic [31:0] bus_addr;
  logic [7:0]  cs_n;
  logic        rw_n, xfer_done, drv_en;

  always #10 clk = ~clk;

  csg_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel_opt(cfg_sel_opt),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .ext_ack(ext_ack), .cs_n(cs_n), .rw_n(rw_n),
    .xfer_done(xfer_done), .drv_en(drv_en)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] sh_base [8];
  logic [31:0] sh_opt  [8];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int ref_region(logic [31:0] a, logic rd);
    for (int i = 0; i < 8; i++) begin
      if (sh_base[i][0] && ((((a ^ sh_base[i]) & sh_opt[i]) & 32'hFFFF_F000) == 32'h0)
          && (!sh_opt[i][0] || (sh_opt[i][1] == rd)))
        return i;
    end
    return -1;
  endfunction

  function automatic logic [31:0] mk_opt(logic [31:0] mask, bit aset, bit wrah,
                                         int ws, bit rwsel, bit rwmsk);
    return (mask & 32'hFFFF_F000) | (32'(aset) << 11) | (32'(wrah) << 10)
         | ((32'(ws) & 32'h1F) << 2) | (32'(rwsel) << 1) | 32'(rwmsk);
  endfunction

  task automatic cfg(int idx, bit opt, logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel_opt = opt; cfg_idx = 3'(idx); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (opt) sh_opt[idx] = d; else sh_base[idx] = d;
  endtask

  // one transfer, compared cycle by cycle against a timeline built from the requirements
  task automatic xfer(string tag, logic [31:0] a, bit rd, int ack_at, bit busy_req);
    int r, st, first, end_k, hold, last, ws;
    bit aset, wrah, pend;
    logic [7:0] e_cs;
    r = ref_region(a, rd);
    if (r >= 0) begin
      aset  = sh_opt[r][11];
      wrah  = sh_opt[r][10];
      ws    = int'(sh_opt[r][6:2]);
      pend  = aset && !rd;
      st    = 1 + int'(aset);
      first = st + int'(pend);
      end_k = first + ws;
      if (ack_at >= first && ack_at < end_k) end_k = ack_at;
      hold  = (!rd && wrah) ? 1 : 0;
      last  = end_k + hold + 2;
    end else begin
      st = 99; first = 99; end_k = -1; hold = 0; last = 4;
    end
    @(posedge clk); #1;
    bus_req = 1'b1; bus_addr = a; bus_rd = rd; ext_ack = 1'b0;
    for (int k = 0; k <= last; k++) begin
      if (k > 0) begin
        @(posedge clk); #1;
        bus_req = busy_req && (k == 2);
        ext_ack = (k == ack_at);
      end
      @(negedge clk);
      e_cs = 8'hFF;
      if (r >= 0 && k >= st && k <= end_k) e_cs[r] = 1'b0;
      chk(tag, $sformatf("cs_n k=%0d", k), 32'(cs_n), 32'(e_cs));
      chk(tag, $sformatf("rw_n k=%0d", k), 32'(rw_n),
          32'(!(r >= 0 && !rd && k >= first && k <= end_k)));
      chk(tag, $sformatf("done k=%0d", k), 32'(xfer_done), 32'(k == end_k));
      chk(tag, $sformatf("drv k=%0d", k), 32'(drv_en),
          32'(r >= 0 && k >= 1 && k <= end_k + hold));
    end
    @(posedge clk); #1;
    bus_req = 1'b0; ext_ack = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      sh_base[i] = 32'h0;
      sh_opt[i]  = 32'hFFFF_F078;
    end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel_opt = 1'b0; cfg_idx = 3'd0; cfg_wdata = 32'h0;
    bus_req = 1'b0; bus_addr = 32'h0; bus_rd = 1'b1; ext_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "cs_n reset", 32'(cs_n), 32'hFF);
    chk("R1", "rw_n reset", 32'(rw_n), 32'h1);
    chk("R1", "done reset", 32'(xfer_done), 32'h0);
    chk("R1", "drv reset", 32'(drv_en), 32'h0);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: all regions invalid after reset
    xfer("R10", 32'h1000_0000, 1'b1, -1, 1'b0);

    // R1/R6: region 0 with reset option word (30 wait states)
    cfg(0, 1'b0, 32'h1000_0001);
    xfer("R1", 32'h1000_0ABC, 1'b1, -1, 1'b0);
    // R7: early acknowledge
    xfer("R7", 32'h1000_0000, 1'b1, 3, 1'b0);
    xfer("R7", 32'h1000_0000, 1'b0, 5, 1'b0);

    // R2/R4/R6: partial mask
    cfg(1, 1'b0, 32'h2000_0001);
    cfg(1, 1'b1, mk_opt(32'hFFF0_0000, 0, 0, 2, 0, 0));
    xfer("R2", 32'h200F_F000, 1'b1, -1, 1'b0);
    xfer("R4", 32'h2000_0000, 1'b0, -1, 1'b0);
    xfer("R2", 32'h2010_0000, 1'b1, -1, 1'b0);

    // R3: overlap with lower priority region 2
    cfg(2, 1'b0, 32'h2000_0001);
    cfg(2, 1'b1, mk_opt(32'hFF00_0000, 0, 0, 1, 0, 0));
    xfer("R3", 32'h2000_1000, 1'b1, -1, 1'b0);
    xfer("R3", 32'h20F0_0000, 1'b1, -1, 1'b0);

    // R11: request during a transfer ignored
    xfer("R11", 32'h2000_0000, 1'b1, -1, 1'b1);

    // R5: setup cycle, delayed write strobe
    cfg(3, 1'b0, 32'h3000_0001);
    cfg(3, 1'b1, mk_opt(32'hFFFF_F000, 1, 0, 1, 0, 0));
    xfer("R5", 32'h3000_0000, 1'b0, -1, 1'b0);
    xfer("R5", 32'h3000_0000, 1'b1, -1, 1'b0);
    xfer("R7", 32'h3000_0000, 1'b0, 2, 1'b0);

    // R8: write hold
    cfg(4, 1'b0, 32'h4000_0001);
    cfg(4, 1'b1, mk_opt(32'hFFFF_F000, 0, 1, 0, 0, 0));
    xfer("R8", 32'h4000_0000, 1'b0, -1, 1'b0);
    xfer("R8", 32'h4000_0000, 1'b1, -1, 1'b0);
    cfg(4, 1'b1, mk_opt(32'hFFFF_F000, 1, 1, 3, 0, 0));
    xfer("R8", 32'h4000_0000, 1'b0, -1, 1'b0);

    // R9: read-only region
    cfg(5, 1'b0, 32'h5000_0001);
    cfg(5, 1'b1, mk_opt(32'hFFFF_F000, 0, 0, 1, 1, 1));
    xfer("R9", 32'h5000_0000, 1'b1, -1, 1'b0);
    xfer("R9", 32'h5000_0000, 1'b0, -1, 1'b0);
    cfg(6, 1'b0, 32'h6000_0001);
    cfg(6, 1'b1, mk_opt(32'hFFFF_F000, 0, 0, 0, 0, 1));
    xfer("R9", 32'h6000_0000, 1'b0, -1, 1'b0);
    xfer("R9", 32'h6000_0000, 1'b1, -1, 1'b0);

    // R10: base written with valid flag clear
    cfg(7, 1'b0, 32'h7000_0000);
    cfg(7, 1'b1, mk_opt(32'hFFFF_F000, 0, 0, 0, 0, 0));
    xfer("R10", 32'h7000_0000, 1'b1, -1, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule